// File: doc/BRIEF.md
# Robbed-Bit Signaling Extractor with Integration

This block sits behind the receive elastic store of a 24-channel T-carrier line. For every channel it picks the robbed signaling bit out of the four signaling frames of each 24-frame multiframe and assembles the channel's four-bit ABCD code. A new code is accepted only when the same code is seen in two multiframes in a row, which filters out single-multiframe errors. The system side reads the accepted code of any channel by putting the channel number on a select input. The code appears on four separate outputs one clock later, lined up with the outgoing channel data.

Three conditions stop the stored codes from changing: a level hold input driven by the alarm logic, and single-cycle slip and recenter pulses from the elastic store. A freeze output, driven from a register, shows when updates are suppressed. After a slip or a recenter pulse, and after hold is released, the freeze stays on through the next full multiframe. This keeps a code that straddles the disturbance from being accepted.

The stream enters one channel byte per clock. The caller supplies the byte's frame number (0 to 23 in the multiframe), its channel number (0 to 23) and the byte's least significant bit.

Top module: `rbs_extract`

## Requirements
- R1: After reset every channel's stored code is 4'b0000, the four signaling outputs are low, and freeze is low.
- R2: With frames numbered 0 to 23, the least significant bit of a channel's byte in frame 5 is bit A, in frame 11 bit B, in frame 17 bit C and in frame 23 bit D. They leave on sigA, sigB, sigC and sigD.
- R3: A channel's code is assembled when its frame-23 byte arrives. It replaces the stored code only if it equals the code assembled in that channel's previous multiframe and updates are not suppressed. The candidate code is recorded whether or not updates are suppressed.
- R4: A code that differs in one multiframe only, then returns to the stored value, leaves the stored code unchanged.
- R5: While hold is high no stored code changes, and freeze is high from the cycle after hold rises.
- R6: A one-cycle slip pulse raises freeze on the next cycle. Freeze then stays high until the second multiframe end after the pulse, where a multiframe end is the valid byte of frame 23, channel 23. No stored code changes while freeze is high or while slip is high.
- R7: A one-cycle recenter pulse has the same effect as a slip pulse. When hold is released, freeze likewise stays high until the second multiframe end that follows.
- R8: The sig outputs show the stored code of the channel selected on outChan one cycle after outChan is applied. A select value of 24 or more gives 4'b1111.
- R9: Bytes with byteValid low, and bytes in frames other than 5, 11, 17 and 23, change no state.
- R10: Each channel's assembly, integration and storage are independent of every other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | A channel byte is presented this cycle |
| frameNum | input | 5 | Frame index of the byte within the multiframe, 0 to 23 |
| chanNum | input | 5 | Channel index of the byte, 0 to 23 |
| chanLsb | input | 1 | Least significant bit of the channel byte |
| hold | input | 1 | Alarm hold level; suppresses updates while high |
| slip | input | 1 | One-cycle pulse when the elastic store slips |
| recenter | input | 1 | One-cycle pulse when the elastic store is recentered |
| outChan | input | 5 | Channel whose stored code is read out |
| sigA | output | 1 | Signaling bit A of the selected channel |
| sigB | output | 1 | Signaling bit B of the selected channel |
| sigC | output | 1 | Signaling bit C of the selected channel |
| sigD | output | 1 | Signaling bit D of the selected channel |
| freeze | output | 1 | High while signaling updates are suppressed |

## Verification
The read-out is due one clock after outChan is driven, and it reflects the stored codes as they stood before that edge. The bench therefore computes each expected code from its model at the moment it drives the select, before the model takes that edge's byte, and compares it at the next falling edge. Freeze is due one clock after a hold, slip or recenter input and after the multiframe-end byte that clears it, so its expected value is taken from the model's counter after each modeled edge. A stored-code change shows on the read-out the cycle after the frame-23 byte that commits it.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

  localparam int SIG_BITS = 4;

  // strobes from control to datapath for the byte presented this cycle
  typedef struct packed {
    logic       capture;   // byte lies in a signaling frame of a valid channel
    logic [1:0] bitSel;    // 0 = A, 1 = B, 2 = C, 3 = D
    logic       commit;    // D byte: assemble and integrate the code
    logic       updateEn;  // stored code may be replaced
  } sigStrobe_t;

endpackage

// File: rtl/rbs_control.sv
module rbs_control
  import rbs_pkg::*;
#(
  parameter int NUM_CH        = 24,
  parameter int FRAMES_PER_MF = 24,
  parameter int SIG_SPACING   = 6,
  parameter int HOLD_MF       = 2,
  parameter int CH_W          = 5,
  parameter int FR_W          = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            byteValid,
  input  logic [FR_W-1:0] frameNum,
  input  logic [CH_W-1:0] chanNum,
  input  logic            hold,
  input  logic            slip,
  input  logic            recenter,
  output sigStrobe_t      strobe,
  output logic            freeze
);

  localparam int CNT_W = $clog2(HOLD_MF + 1);

  logic             inRange;
  logic             sigFrame;
  logic             mfEnd;
  logic             disturb;
  logic [CNT_W-1:0] freezeCnt;

  assign inRange  = (int'(frameNum) < FRAMES_PER_MF) && (int'(chanNum) < NUM_CH);
  assign sigFrame = (frameNum % FR_W'(SIG_SPACING)) == FR_W'(SIG_SPACING - 1);
  assign mfEnd    = byteValid && (frameNum == FR_W'(FRAMES_PER_MF - 1))
                    && (chanNum == CH_W'(NUM_CH - 1));
  assign disturb  = hold || slip || recenter;

  always_comb begin
    strobe.capture  = byteValid && inRange && sigFrame;
    strobe.bitSel   = 2'(frameNum / FR_W'(SIG_SPACING));
    strobe.commit   = strobe.capture && (strobe.bitSel == 2'd3);
    strobe.updateEn = !disturb && (freezeCnt == '0);
  end

  // reloads on every disturbance, counts down on multiframe ends
  always_ff @(posedge clk) begin
    if (!rstN) begin
      freezeCnt <= '0;
    end else if (disturb) begin
      freezeCnt <= CNT_W'(HOLD_MF);
    end else if (mfEnd && (freezeCnt != '0)) begin
      freezeCnt <= freezeCnt - 1'b1;
    end
  end

  assign freeze = (freezeCnt != '0);

  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    hold |=> freeze); // R5
  AST_SLIP_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    slip |=> freeze); // R6
  AST_RECENTER_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    recenter |=> freeze); // R7
  AST_RELEASE_AT_MF_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(freeze) |-> $past(mfEnd)); // R6

endmodule

// File: rtl/rbs_datapath.sv
module rbs_datapath
  import rbs_pkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int CH_W   = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  sigStrobe_t          strobe,
  input  logic [CH_W-1:0]     chanNum,
  input  logic                chanLsb,
  input  logic [CH_W-1:0]     outChan,
  output logic [SIG_BITS-1:0] sigOut
);

  // partial code A,B,C per channel (bit 2 = A)
  logic [NUM_CH-1:0][SIG_BITS-2:0] colMem;
  logic [NUM_CH-1:0][SIG_BITS-1:0] pendMem;
  logic [NUM_CH-1:0][SIG_BITS-1:0] storedMem;
  logic [SIG_BITS-1:0]             cand;

  assign cand = {colMem[chanNum], chanLsb};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colMem    <= '0;
      pendMem   <= '0;
      storedMem <= '0;
    end else if (strobe.capture) begin
      if (!strobe.commit) begin
        colMem[chanNum][2'd2 - strobe.bitSel] <= chanLsb;
      end else begin
        pendMem[chanNum] <= cand;
        if (strobe.updateEn && (cand == pendMem[chanNum])) begin
          storedMem[chanNum] <= cand;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sigOut <= '0;
    end else if (int'(outChan) < NUM_CH) begin
      sigOut <= storedMem[outChan];
    end else begin
      sigOut <= '1;
    end
  end

  AST_NO_UPDATE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.updateEn |=> $stable(storedMem)); // R5
  AST_COMMIT_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(storedMem)); // R3
  AST_IDLE_NO_STATE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> ($stable(colMem) && $stable(pendMem))); // R9

endmodule

// File: rtl/rbs_extract.sv
module rbs_extract
  import rbs_pkg::*;
#(
  parameter int NUM_CH        = 24,
  parameter int FRAMES_PER_MF = 24,
  parameter int SIG_SPACING   = 6,
  parameter int HOLD_MF       = 2,
  localparam int CH_W         = $clog2(NUM_CH),
  localparam int FR_W         = $clog2(FRAMES_PER_MF)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            byteValid,
  input  logic [FR_W-1:0] frameNum,
  input  logic [CH_W-1:0] chanNum,
  input  logic            chanLsb,
  input  logic            hold,
  input  logic            slip,
  input  logic            recenter,
  input  logic [CH_W-1:0] outChan,
  output logic            sigA,
  output logic            sigB,
  output logic            sigC,
  output logic            sigD,
  output logic            freeze
);

  sigStrobe_t          strobe;
  logic [SIG_BITS-1:0] sigOut;

  rbs_control #(
    .NUM_CH(NUM_CH), .FRAMES_PER_MF(FRAMES_PER_MF), .SIG_SPACING(SIG_SPACING),
    .HOLD_MF(HOLD_MF), .CH_W(CH_W), .FR_W(FR_W)
  ) u_control (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .frameNum(frameNum),
    .chanNum(chanNum), .hold(hold), .slip(slip), .recenter(recenter),
    .strobe(strobe), .freeze(freeze)
  );

  rbs_datapath #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .chanNum(chanNum),
    .chanLsb(chanLsb), .outChan(outChan), .sigOut(sigOut)
  );

  assign {sigA, sigB, sigC, sigD} = sigOut;

endmodule

// File: tb/rbs_extract_tb.sv
module rbs_extract_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN = 1'b0;
  logic       byteValid = 1'b0, chanLsb = 1'b0;
  logic       hold = 1'b0, slip = 1'b0, recenter = 1'b0;
  logic [4:0] frameNum = '0, chanNum = '0, outChan = '0;
  logic       sigA, sigB, sigC, sigD, freeze;

  rbs_extract u_dut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .frameNum(frameNum),
    .chanNum(chanNum), .chanLsb(chanLsb), .hold(hold), .slip(slip),
    .recenter(recenter), .outChan(outChan), .sigA(sigA), .sigB(sigB),
    .sigC(sigC), .sigD(sigD), .freeze(freeze)
  );

  // reference model
  logic [3:0] mStored [24];
  logic [3:0] mPend   [24];
  logic [2:0] mCol    [24];
  int         mCnt;
  logic [3:0] curVals [24];
  logic [3:0] expSig;
  logic       primed = 1'b0;
  logic       holdLvl = 1'b0;
  int         prevOc;
  int         vecs = 0, fails = 0;
  string      curReq = "R1";
  logic       done = 1'b0;

  function automatic logic [3:0] readExp(input int oc);
    return (oc < 24) ? mStored[oc] : 4'b1111;
  endfunction

  task automatic modelStep(input logic v, input int f, input int c, input logic lsb,
                           input logic h, input logic s, input logic r);
    logic evt;
    logic en;
    logic [3:0] cand;
    evt = h | s | r;
    en  = !evt && (mCnt == 0);
    if (v && f < 24 && c < 24 && (f % 6) == 5) begin
      if (f / 6 < 3) mCol[c][2 - f / 6] = lsb;
      else begin
        cand = {mCol[c], lsb};
        if (en && cand == mPend[c]) mStored[c] = cand;
        mPend[c] = cand;
      end
    end
    if (evt) mCnt = 2;
    else if (v && f == 23 && c == 23 && mCnt > 0) mCnt = mCnt - 1;
  endtask

  task automatic drive(input logic v, input int f, input int c, input logic lsb,
                       input logic h, input logic s, input logic r, input int oc);
    @(negedge clk);
    if (primed && !done) begin
      vecs++;
      if ({sigA, sigB, sigC, sigD} !== expSig) begin
        fails++;
        $display("FAIL %s sig chan %0d: got %b exp %b", curReq, prevOc,
                 {sigA, sigB, sigC, sigD}, expSig);
      end
      vecs++;
      if (freeze !== (mCnt != 0)) begin
        fails++;
        $display("FAIL %s freeze: got %b exp %b", curReq, freeze, (mCnt != 0));
      end
    end
    byteValid = v; frameNum = 5'(f); chanNum = 5'(c); chanLsb = lsb;
    hold = h; slip = s; recenter = r; outChan = 5'(oc);
    expSig = readExp(oc);
    prevOc = oc;
    primed = 1'b1;
    modelStep(v, f, c, lsb, h, s, r);
  endtask

  task automatic sendMf(input int slipAt, input int recAt);
    for (int f = 0; f < 24; f++) begin
      for (int c = 0; c < 24; c++) begin
        logic lsb;
        lsb = ((f % 6) == 5) ? curVals[c][3 - f / 6] : 1'($urandom);
        drive(1'b1, f, c, lsb, holdLvl, (f * 24 + c) == slipAt,
              (f * 24 + c) == recAt, int'($urandom_range(31, 0)));
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++)
      drive(1'b0, int'($urandom_range(23, 0)), int'($urandom_range(23, 0)),
            1'($urandom), holdLvl, 1'b0, 1'b0, int'($urandom_range(31, 0)));
  endtask

  task automatic readAll();
    for (int c = 0; c < 25; c++)
      drive(1'b0, 0, 0, 1'b0, holdLvl, 1'b0, 1'b0, c);
  endtask

  initial begin
    void'($urandom(32'd2176));
    for (int c = 0; c < 24; c++) begin
      mStored[c] = '0; mPend[c] = '0; mCol[c] = '0; curVals[c] = '0;
    end
    mCnt = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    curReq = "R1"; readAll(); idle(10);

    // directed pattern: first multiframe must not update
    for (int c = 0; c < 24; c++) curVals[c] = 4'(c) ^ 4'h9;
    curReq = "R4"; sendMf(-1, -1); readAll();
    curReq = "R2"; sendMf(-1, -1); readAll();
    curReq = "R3"; sendMf(-1, -1); readAll();

    // one channel alone changes
    curVals[7] = 4'hC;
    curReq = "R10"; sendMf(-1, -1); sendMf(-1, -1); readAll();

    // idle bytes and junk in other frames change nothing
    curReq = "R9"; idle(200); sendMf(-1, -1); readAll();

    // single-multiframe glitch
    curVals[3] = 4'h6; curReq = "R4"; sendMf(-1, -1);
    curVals[3] = 4'(3) ^ 4'h9; sendMf(-1, -1); readAll();

    // hold suppresses updates, then the release window
    for (int c = 0; c < 24; c++) curVals[c] = ~curVals[c];
    holdLvl = 1'b1; curReq = "R5"; sendMf(-1, -1); sendMf(-1, -1); readAll();
    holdLvl = 1'b0; curReq = "R7"; readAll(); sendMf(-1, -1); sendMf(-1, -1);
    sendMf(-1, -1); readAll();

    // slip mid multiframe
    for (int c = 0; c < 24; c++) curVals[c] = 4'(c * 5);
    curReq = "R6"; sendMf(-1, -1); sendMf(300, -1); sendMf(-1, -1);
    sendMf(-1, -1); readAll();

    // recenter on the very last byte
    for (int c = 0; c < 24; c++) curVals[c] = 4'(c * 3 + 1);
    curReq = "R7"; sendMf(-1, 575); sendMf(-1, -1); sendMf(-1, -1); readAll();

    // random traffic with random disturbances
    curReq = "R8";
    for (int m = 0; m < 20; m++) begin
      int kind;
      for (int c = 0; c < 24; c++)
        if ($urandom_range(2, 0) == 0) curVals[c] = 4'($urandom);
      kind = int'($urandom_range(5, 0));
      if (kind == 2) holdLvl = ~holdLvl;
      sendMf(kind == 0 ? int'($urandom_range(575, 0)) : -1,
             kind == 1 ? int'($urandom_range(575, 0)) : -1);
      idle(5);
    end
    holdLvl = 1'b0; readAll();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

endmodule